// File: doc/BRIEF.md
# Timer Interrupt Status and Enable Block

This block collects the one-cycle event pulses that the counter logic of a multi-channel timer produces and turns them into per-channel interrupt lines. Each channel owns a six-bit sticky status word and a six-bit enable word. A pulse on any event input latches its bit. The latched bit stays set until software reads that channel's status word. A channel's interrupt line is high while any status bit has its enable bit set.

Software reaches the block through a simple word-addressed register port with a select, a write flag, an address and write data. Read data is registered and appears in the cycle after the access. A status read returns the status word as it stood before the access and clears it at the same clock edge. The interrupt line therefore drops in the next cycle unless a new enabled event arrived. Writes to a status word are discarded, so a status bit can only be cleared by reading it.

Top module: `tmr_irq_regs`

## Requirements
- R1: After reset, every status word and every enable word is zero, every `irq_o` bit is low, and `bus_rdata` is zero.
- R2: A one-cycle pulse on event bit b of channel k sets status bit b of that channel. The bit stays set through idle cycles until a status read of channel k. Event bits within a channel are: 0 interval, 1 match 1, 2 match 2, 3 match 3, 4 overflow, 5 external event. Channel k uses `evt_i[6k+5:6k]`.
- R3: A read of address 0x54 + 4k returns channel k's status word in bits 5:0, with upper bits zero, on `bus_rdata` in the cycle after the access. The same edge clears that status word.
- R4: When a clearing read meets no new enabled event, `irq_o[k]` is low in the cycle right after the read.
- R5: A write to any status address (0x54, 0x58, 0x5C) leaves the status words unchanged.
- R6: A write to 0x60 + 4k stores bits 5:0 of the write data as channel k's enable word. A read of that address returns the stored word with bits 31:6 zero.
- R7: `irq_o[k]` is the OR of (status AND enable) of channel k. A masked event still latches its status bit but does not raise the line.
- R8: An event pulse in the same cycle as a clearing read of its channel is kept. The read returns the old word, and the new bit is set afterwards.
- R9: A status read of one channel leaves the status of every other channel untouched.
- R10: A read of an unmapped or misaligned address returns zero. A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| evt_i | input | 18 | Event pulses, six per channel |
| irq_o | output | 3 | Per-channel interrupt lines |

## Verification
Single isolated pulses show that status is sticky and is cleared only by a read. Writes of all-ones and all-zeros to status addresses are then followed by reads, which separates a read-only status word from a write-to-clear one. Enabled and masked pulses are applied to the same channel. This shows that the line follows the mask while the status latches regardless of it, and that the line falls in the cycle right after a read. Events that coincide with a clearing read are tried on a different bit and on the same bit, to catch a clear that wins over a new event. Pulses on all channels followed by a read of a single channel expose any cross-channel clearing.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
   localparam int unsigned EVT_BITS    = 6;
   localparam int unsigned BIT_INTERVAL = 0;
   localparam int unsigned BIT_MATCH1   = 1;
   localparam int unsigned BIT_MATCH2   = 2;
   localparam int unsigned BIT_MATCH3   = 3;
   localparam int unsigned BIT_OVERFLOW = 4;
   localparam int unsigned BIT_EXTEVT   = 5;
   localparam int unsigned WORD_STRIDE  = 4;
endpackage

// File: rtl/tmr_irq_decode.sv
module tmr_irq_decode #(
   parameter int unsigned NUM_CH    = 3,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned STAT_BASE = 'h54,
   parameter int unsigned EN_BASE   = 'h60,
   parameter int unsigned STRIDE    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [NUM_CH-1:0] stat_hit_o,
   output logic [NUM_CH-1:0] en_hit_o
);
   for (genvar k = 0; k < NUM_CH; k++) begin : g_hit
      localparam logic [ADDR_W-1:0] SA = ADDR_W'(STAT_BASE + k*STRIDE);
      localparam logic [ADDR_W-1:0] EA = ADDR_W'(EN_BASE + k*STRIDE);
      assign stat_hit_o[k] = (addr_i == SA);
      assign en_hit_o[k]   = (addr_i == EA);
   end

   AST_DEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stat_hit_o, en_hit_o})) else $error("decode overlap"); // R10
endmodule

// File: rtl/tmr_irq_chan.sv
module tmr_irq_chan #(
   parameter int unsigned EVT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] evt_i,
   input  logic             clr_i,
   input  logic             en_we_i,
   input  logic [EVT_W-1:0] en_wdata_i,
   output logic [EVT_W-1:0] status_o,
   output logic [EVT_W-1:0] enable_o,
   output logic             irq_o
);
   logic [EVT_W-1:0] status_q, status_d;
   logic [EVT_W-1:0] enable_q;

   // a clearing read and a fresh event in one cycle: event wins
   always_comb begin
      status_d = clr_i ? '0 : status_q;
      status_d = status_d | evt_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         enable_q <= '0;
      end else begin
         status_q <= status_d;
         if (en_we_i) enable_q <= en_wdata_i;
      end
   end

   assign status_o = status_q;
   assign enable_o = enable_q;
   assign irq_o    = |(status_q & enable_q);

   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> ((status_q & $past(status_q)) == $past(status_q))) else $error("status lost"); // R2
   AST_CLR_KEEP_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (status_q == $past(evt_i))) else $error("clear wrong"); // R8
   AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && evt_i == '0) |=> !irq_o) else $error("irq held"); // R4
   AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_q == '0) |-> !irq_o) else $error("irq unmasked"); // R7
endmodule

// File: rtl/tmr_irq_rdmux.sv
module tmr_irq_rdmux #(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned EVT_W  = 6,
   parameter int unsigned DATA_W = 32
) (
   input  logic [NUM_CH-1:0]       stat_hit_i,
   input  logic [NUM_CH-1:0]       en_hit_i,
   input  logic [NUM_CH*EVT_W-1:0] status_i,
   input  logic [NUM_CH*EVT_W-1:0] enable_i,
   output logic [DATA_W-1:0]       word_o
);
   always_comb begin
      word_o = '0;
      for (int k = 0; k < NUM_CH; k++) begin
         if (stat_hit_i[k]) word_o = word_o | DATA_W'(status_i[k*EVT_W +: EVT_W]);
         if (en_hit_i[k])   word_o = word_o | DATA_W'(enable_i[k*EVT_W +: EVT_W]);
      end
   end
endmodule

// File: rtl/tmr_irq_regs.sv
module tmr_irq_regs #(
   parameter int unsigned NUM_CH    = 3,
   parameter int unsigned EVT_W     = tmr_irq_pkg::EVT_BITS,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned STAT_BASE = 'h54,
   parameter int unsigned EN_BASE   = 'h60
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_sel,
   input  logic                    bus_wr,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   input  logic [NUM_CH*EVT_W-1:0] evt_i,
   output logic [NUM_CH-1:0]       irq_o
);
   localparam int unsigned STRIDE   = tmr_irq_pkg::WORD_STRIDE;
   localparam int unsigned STAT_END = STAT_BASE + NUM_CH*STRIDE;
   localparam int unsigned EN_END   = EN_BASE + NUM_CH*STRIDE;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end
   if (EVT_W > DATA_W) begin : g_bad_w
      $error("EVT_W wider than data word");
   end
   if (STAT_END > EN_BASE && EN_END > STAT_BASE) begin : g_bad_map
      $error("status and enable windows overlap");
   end
   if (EN_END > (1 << ADDR_W) || STAT_END > (1 << ADDR_W)) begin : g_bad_addr
      $error("register window exceeds address space");
   end

   logic              rd_acc, wr_acc;
   logic [NUM_CH-1:0] stat_hit, en_hit;
   logic [NUM_CH*EVT_W-1:0] stat_all, en_all;
   logic [DATA_W-1:0] rd_word;

   assign rd_acc = bus_sel && !bus_wr;
   assign wr_acc = bus_sel &&  bus_wr;

   tmr_irq_decode #(
      .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .STAT_BASE(STAT_BASE),
      .EN_BASE(EN_BASE), .STRIDE(STRIDE)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .addr_i(bus_addr),
      .stat_hit_o(stat_hit), .en_hit_o(en_hit)
   );

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      tmr_irq_chan #(.EVT_W(EVT_W)) u_ch (
         .clk(clk), .rst_n(rst_n),
         .evt_i(evt_i[k*EVT_W +: EVT_W]),
         .clr_i(rd_acc && stat_hit[k]),
         .en_we_i(wr_acc && en_hit[k]),
         .en_wdata_i(bus_wdata[EVT_W-1:0]),
         .status_o(stat_all[k*EVT_W +: EVT_W]),
         .enable_o(en_all[k*EVT_W +: EVT_W]),
         .irq_o(irq_o[k])
      );

      AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_acc && stat_hit[k]) |=>
         (stat_all[k*EVT_W +: EVT_W] ==
          ($past(stat_all[k*EVT_W +: EVT_W]) | $past(evt_i[k*EVT_W +: EVT_W]))))
         else $error("status written"); // R5
      AST_RD_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_acc && stat_hit[k]) |=>
         (bus_rdata == DATA_W'($past(stat_all[k*EVT_W +: EVT_W]))))
         else $error("read data mismatch"); // R3
   end

   tmr_irq_rdmux #(.NUM_CH(NUM_CH), .EVT_W(EVT_W), .DATA_W(DATA_W)) u_mux (
      .stat_hit_i(stat_hit), .en_hit_i(en_hit),
      .status_i(stat_all), .enable_i(en_all), .word_o(rd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (rd_acc) bus_rdata <= rd_word;
   end

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && stat_hit == '0 && en_hit == '0) |=> (bus_rdata == '0))
      else $error("unmapped read nonzero"); // R10
endmodule

// File: tb/tmr_irq_regs_bench.sv
module tmr_irq_regs_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [17:0] evt_i = '0;
   logic [2:0]  irq_o;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   tmr_irq_regs u_tmr_irq_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_i(evt_i), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [17:0] ev(input int ch, input int b);
      logic [17:0] v = '0;
      v[ch*6 + b] = 1'b1;
      return v;
   endfunction

   task automatic pulse(input logic [17:0] v);
      evt_i = v;
      @(negedge clk);
      evt_i = '0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [17:0] v, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; evt_i = v;
      @(negedge clk);
      bus_sel = 1'b0; evt_i = '0;
      d = bus_rdata;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] w);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = w;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 irq", 32'(irq_o), 0);
      chk("R1 rdata", bus_rdata, 0);
      for (int k = 0; k < 3; k++) begin
         rd(8'(8'h54 + 4*k), '0, d); chk("R1 status", d, 0);
         rd(8'(8'h60 + 4*k), '0, d); chk("R1 enable", d, 0);
      end
   endtask

   task automatic t_sticky();
      logic [31:0] d;
      pulse(ev(0, 1));
      repeat (3) @(negedge clk);
      rd(8'h54, '0, d); chk("R2 sticky match1", d, 32'h02);
      rd(8'h54, '0, d); chk("R3 cleared by read", d, 0);
   endtask

   task automatic t_irq();
      logic [31:0] d;
      wr(8'h64, 32'h10);
      pulse(ev(1, 4));
      chk("R7 enabled irq up", 32'(irq_o), 32'h2);
      rd(8'h58, '0, d);
      chk("R3 overflow read", d, 32'h10);
      chk("R4 irq drops after read", 32'(irq_o), 0);
      pulse(ev(1, 0));
      chk("R7 masked no irq", 32'(irq_o), 0);
      rd(8'h58, '0, d); chk("R7 masked still latched", d, 32'h01);
      wr(8'h64, 32'h0);
   endtask

   task automatic t_wr_ignored();
      logic [31:0] d;
      pulse(ev(2, 3));
      wr(8'h5C, 32'hFFFF_FFFF);
      wr(8'h5C, 32'h0);
      rd(8'h5C, '0, d); chk("R5 write ignored ch2", d, 32'h08);
      wr(8'h58, 32'h3F);
      rd(8'h58, '0, d); chk("R5 write no set ch1", d, 0);
   endtask

   task automatic t_enable();
      logic [31:0] d;
      wr(8'h64, 32'hFFFF_FFFF);
      rd(8'h64, '0, d); chk("R6 enable masked width", d, 32'h3F);
      chk("R7 enable alone no irq", 32'(irq_o), 0);
      wr(8'h60, 32'h15);
      rd(8'h60, '0, d); chk("R6 enable readback", d, 32'h15);
      wr(8'h64, 32'h0);
      wr(8'h60, 32'h0);
   endtask

   task automatic t_coincident();
      logic [31:0] d;
      wr(8'h60, 32'h01);
      pulse(ev(0, 0));
      rd(8'h54, ev(0, 2), d); chk("R8 read returns old", d, 32'h01);
      rd(8'h54, '0, d); chk("R8 other bit kept", d, 32'h04);
      pulse(ev(0, 0));
      rd(8'h54, ev(0, 0), d); chk("R8 same bit read", d, 32'h01);
      chk("R8 irq held by new event", 32'(irq_o), 32'h1);
      rd(8'h54, '0, d); chk("R8 same bit kept", d, 32'h01);
      wr(8'h60, 32'h0);
   endtask

   task automatic t_indep();
      logic [31:0] d;
      pulse(ev(0, 5) | ev(1, 5) | ev(2, 5));
      rd(8'h58, '0, d); chk("R9 ch1 read", d, 32'h20);
      rd(8'h54, '0, d); chk("R9 ch0 untouched", d, 32'h20);
      rd(8'h5C, '0, d); chk("R9 ch2 untouched", d, 32'h20);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      wr(8'h60, 32'h07);
      pulse(ev(0, 1));
      rd(8'h50, '0, d); chk("R10 unmapped read", d, 0);
      rd(8'h55, '0, d); chk("R10 misaligned read", d, 0);
      wr(8'h6C, 32'h3F);
      wr(8'h61, 32'h3F);
      rd(8'h60, '0, d); chk("R10 write no effect", d, 32'h07);
      rd(8'h68, '0, d); chk("R10 ch2 enable untouched", d, 0);
      rd(8'h54, '0, d); chk("R10 status survives stray reads", d, 32'h02);
      wr(8'h60, 32'h0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sticky();
      t_irq();
      t_wr_ignored();
      t_enable();
      t_coincident();
      t_indep();
      t_unmapped();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule